// File: doc/BRIEF.md
# Paged Address Counter with Write-Load Buffer

This block keeps the internal byte address of a 32K x 8 serial memory and collects the bytes of a write transaction before they are committed. The address is 15 bits wide. The upper 9 bits select one of 512 pages, and the lower 6 bits select a byte within a 64-byte page. The bus interface loads a new address when a transaction supplies one. It then either stores incoming write bytes or steps through read data.

Write bytes go into a 64-entry buffer at the current byte offset. Only that offset advances, and it wraps within the page, so the page field never changes during a write. A per-entry valid mask records which entries the current write transaction has filled. The write sequencer reads the page number and the buffered entries through an indexed commit port.

Reads take their byte from an external synchronous memory. That memory returns the word at the presented address one clock after the address appears. Each read advances the full 15-bit counter, which wraps from the top of the space to zero. The counter comes out of reset at zero. Software must still load an address before its first operation.

Top module: `page_addr_buffer`

## Requirements
- R1: After reset, `curAddr` is 0, `validMask` is all zeros, `rdData` is 0 and every buffer entry reads 0.
- R2: A `loadAddr` pulse makes `curAddr` equal `loadValue` at the next clock edge. A `wrByte` or `rdNext` in the same cycle is dropped.
- R3: A `wrByte` pulse without `loadAddr` writes `wrData` into buffer entry `curAddr[5:0]`. The offset `curAddr[5:0]` then increases by one modulo 64, and `curAddr[14:6]` stays unchanged, so offset 63 is followed by offset 0.
- R4: Each stored byte sets the `validMask` bit that matches its offset. A later byte stored at the same offset replaces the earlier value.
- R5: A `rdNext` pulse with neither `loadAddr` nor `wrByte` copies `memQ` into `rdData` and increases `curAddr` by one modulo 32768, so 0x7FFF is followed by 0x0000.
- R6: A `wrStart` pulse clears `validMask` at the next edge. When `wrByte` is accepted in the same cycle, only that byte's bit is set afterwards. Buffered data is left as it was.
- R7: `commitData` and `commitValid` show, in the same cycle, the buffer entry and mask bit selected by `commitIdx`. `pageAddr` always equals `curAddr[14:6]`.
- R8: When `wrByte` and `rdNext` arrive together without `loadAddr`, the write wins. The counter follows the page-wrap rule and `rdData` does not change.
- R9: Loading 64 bytes from offset 32 fills offsets 32..63 and then 0..31, and leaves the counter at offset 32 of the same page. Any further bytes overwrite entries in that same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadAddr | input | 1 | Load the counter from `loadValue` |
| loadValue | input | 15 | Address to load |
| wrStart | input | 1 | Start of a write transaction; clears the valid mask |
| wrByte | input | 1 | Store `wrData` at the current offset |
| wrData | input | 8 | Write byte |
| rdNext | input | 1 | Capture the read byte and step the counter |
| memQ | input | 8 | Data from the synchronous memory at `curAddr` |
| commitIdx | input | 6 | Buffer entry selected for the sequencer |
| curAddr | output | 15 | Current address counter, also the memory address |
| pageAddr | output | 9 | Page field of the counter |
| validMask | output | 64 | Entries loaded in the current write transaction |
| rdData | output | 8 | Last byte read |
| commitData | output | 8 | Buffer entry at `commitIdx` |
| commitValid | output | 1 | Valid bit at `commitIdx` |

## Verification
The counter, the valid mask, the buffer and `rdData` are each a single register stage. Their effect is due at the first clock edge after the strobe. The commit port and `pageAddr` are combinational from those registers, so they are due in the same cycle as the register change.

The bench drives strobes just after a falling edge and updates its reference model at the rising edge. It compares every output at the following falling edge, exactly one edge after the stimulus. Because the external memory lags the address by one edge, the bench issues a `rdNext` only after a cycle in which the counter did not move.

// File: rtl/addr_buf_pkg.sv
package addr_buf_pkg;
  typedef struct packed {
    logic load;
    logic clearMask;
    logic storeByte;
    logic stepFull;
  } strobes_t;
endpackage

// File: rtl/addr_buf_ctrl.sv
module addr_buf_ctrl
  import addr_buf_pkg::*;
(
  input  logic     loadAddr,
  input  logic     wrStart,
  input  logic     wrByte,
  input  logic     rdNext,
  output strobes_t strobes
);
  // Priority: address load, then byte store, then read step.
  always_comb begin
    strobes.load      = loadAddr;
    strobes.clearMask = wrStart;
    strobes.storeByte = wrByte & ~loadAddr;
    strobes.stepFull  = rdNext & ~loadAddr & ~wrByte;
  end
endmodule

// File: rtl/addr_buf_dp.sv
module addr_buf_dp
  import addr_buf_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFFS_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              strobes,
  input  logic [ADDR_W-1:0]     loadValue,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [DATA_W-1:0]     memQ,
  input  logic [OFFS_W-1:0]     commitIdx,
  output logic [ADDR_W-1:0]     curAddr,
  output logic [(1<<OFFS_W)-1:0] validMask,
  output logic [DATA_W-1:0]     rdData,
  output logic [DATA_W-1:0]     commitData,
  output logic                  commitValid
);
  localparam int DEPTH  = 1 << OFFS_W;
  localparam int PAGE_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DEPTH-1:0]  maskQ, maskNext;
  logic [DATA_W-1:0] rdQ;
  logic [DATA_W-1:0] bufQ [DEPTH];
  logic [OFFS_W-1:0] offs, offsInc;
  logic [PAGE_W-1:0] page;

  assign offs    = addrQ[OFFS_W-1:0];
  assign page    = addrQ[ADDR_W-1:OFFS_W];
  assign offsInc = offs + OFFS_W'(1);

  always_comb begin
    maskNext = strobes.clearMask ? '0 : maskQ;
    if (strobes.storeByte) maskNext[offs] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      maskQ <= '0;
      rdQ   <= '0;
    end else begin
      maskQ <= maskNext;
      if (strobes.load)           addrQ <= loadValue;
      else if (strobes.storeByte) addrQ <= {page, offsInc};
      else if (strobes.stepFull)  addrQ <= addrQ + ADDR_W'(1);
      if (strobes.stepFull) rdQ <= memQ;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) bufQ[i] <= '0;
      else if (strobes.storeByte && offs == OFFS_W'(i)) bufQ[i] <= wrData;
    end
  end

  assign curAddr     = addrQ;
  assign validMask   = maskQ;
  assign rdData      = rdQ;
  assign commitData  = bufQ[commitIdx];
  assign commitValid = maskQ[commitIdx];

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte && !strobes.load |=> curAddr[ADDR_W-1:OFFS_W] == $past(page)); // R3
  AST_OFFS_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte && !strobes.load && offs == '1 |=> curAddr[OFFS_W-1:0] == '0); // R3
  AST_MASK_MARK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |=> validMask[$past(offs)]); // R4
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearMask |=> $countones(validMask) <= 1); // R6
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stepFull |=> $stable(rdData)); // R8
endmodule

// File: rtl/page_addr_buffer.sv
module page_addr_buffer
  import addr_buf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadAddr,
  input  logic [14:0] loadValue,
  input  logic        wrStart,
  input  logic        wrByte,
  input  logic [7:0]  wrData,
  input  logic        rdNext,
  input  logic [7:0]  memQ,
  input  logic [5:0]  commitIdx,
  output logic [14:0] curAddr,
  output logic [8:0]  pageAddr,
  output logic [63:0] validMask,
  output logic [7:0]  rdData,
  output logic [7:0]  commitData,
  output logic        commitValid
);
  strobes_t strobes;

  addr_buf_ctrl uCtrl (
    .loadAddr (loadAddr),
    .wrStart  (wrStart),
    .wrByte   (wrByte),
    .rdNext   (rdNext),
    .strobes  (strobes)
  );

  addr_buf_dp #(.ADDR_W(15), .OFFS_W(6), .DATA_W(8)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .loadValue   (loadValue),
    .wrData      (wrData),
    .memQ        (memQ),
    .commitIdx   (commitIdx),
    .curAddr     (curAddr),
    .validMask   (validMask),
    .rdData      (rdData),
    .commitData  (commitData),
    .commitValid (commitValid)
  );

  assign pageAddr = curAddr[14:6];

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    loadAddr |=> curAddr == $past(loadValue)); // R2
  AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    rdNext && !loadAddr && !wrByte && curAddr == 15'h7FFF |=> curAddr == 15'h0000); // R5
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    rdNext && !loadAddr && !wrByte |=> rdData == $past(memQ)); // R5
endmodule

// File: tb/tb_page_addr_buffer.sv
`timescale 1ns/1ps
module tb_page_addr_buffer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, loadAddr, wrStart, wrByte, rdNext, commitValid;
  logic [14:0] loadValue, curAddr;
  logic [7:0]  wrData, memQ, rdData, commitData;
  logic [5:0]  commitIdx;
  logic [8:0]  pageAddr;
  logic [63:0] validMask;

  int checks = 0, failures = 0;
  bit done = 0;

  page_addr_buffer dut (.*);

  function automatic logic [7:0] memFn(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1};
  endfunction

  always @(posedge clk) memQ <= memFn(curAddr);

  // Behavioural reference model.
  int          refAddr;
  logic [7:0]  refBuf [64];
  logic [63:0] refMask;
  logic [7:0]  refRd;

  always @(posedge clk) begin
    if (!rstN) begin
      refAddr <= 0; refMask <= '0; refRd <= '0;
      for (int i = 0; i < 64; i++) refBuf[i] <= '0;
    end else begin
      logic [63:0] m;
      m = wrStart ? 64'd0 : refMask;
      if (loadAddr) refAddr <= loadValue;
      else if (wrByte) begin
        m[refAddr % 64] = 1'b1;
        refBuf[refAddr % 64] <= wrData;
        refAddr <= (refAddr / 64) * 64 + ((refAddr + 1) % 64);
      end else if (rdNext) begin
        refRd   <= memFn(refAddr[14:0]);
        refAddr <= (refAddr + 1) % 32768;
      end
      refMask <= m;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input string req);
    check(curAddr == refAddr[14:0], req, "curAddr", curAddr, refAddr);
    check(pageAddr == refAddr[14:6], "R7", "pageAddr", pageAddr, refAddr[14:6]);
    check(validMask == refMask, req, "validMask", validMask, refMask);
    check(rdData == refRd, req, "rdData", rdData, refRd);
    check(commitData == refBuf[commitIdx], "R7", "commitData", commitData, refBuf[commitIdx]);
    check(commitValid == refMask[commitIdx], "R7", "commitValid", commitValid, refMask[commitIdx]);
  endtask

  task automatic clearIn();
    loadAddr = 0; wrStart = 0; wrByte = 0; rdNext = 0;
  endtask

  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    compareAll(req);
    clearIn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    bit prevChg;
    int k;
    clearIn(); rstN = 0; loadValue = '0; wrData = '0; commitIdx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(curAddr == 0 && validMask == 0 && rdData == 0, "R1", "reset outs",
          {curAddr, rdData}, 0);
    check(commitData == 0, "R1", "reset buffer", commitData, 0);
    rstN = 1;
    step("R1");

    // R2: load with write start
    loadAddr = 1; wrStart = 1; loadValue = 15'h1234; step("R2");
    // R3: a few bytes from offset 0x34
    for (int i = 0; i < 5; i++) begin
      wrByte = 1; wrData = 8'hA0 + 8'(i); commitIdx = 6'(52 + i); step("R3");
    end

    // R9: 64 bytes from offset 32 of page 5
    loadAddr = 1; wrStart = 1; loadValue = 15'h0160; step("R2");
    for (int i = 0; i < 64; i++) begin
      wrByte = 1; wrData = 8'h40 + 8'(i); step("R9");
    end
    check(curAddr == 15'h0160, "R9", "end address", curAddr, 15'h0160);
    commitIdx = 6'd0; #0;
    check(commitData == 8'h60, "R9", "offset0 data", commitData, 8'h60);
    for (int i = 0; i < 64; i++) begin
      commitIdx = 6'(i); step("R7");
    end
    // R4: overwrite offsets 32..34
    for (int i = 0; i < 3; i++) begin
      wrByte = 1; wrData = 8'hE0 + 8'(i); commitIdx = 6'(32 + i); step("R4");
    end
    commitIdx = 6'd33; #0;
    check(commitData == 8'hE1, "R4", "overwrite", commitData, 8'hE1);

    // R3: offset wrap at top of space keeps page
    loadAddr = 1; loadValue = 15'h7FFF; step("R2");
    wrByte = 1; wrData = 8'h5A; step("R3");
    check(curAddr == 15'h7FC0, "R3", "page wrap", curAddr, 15'h7FC0);

    // R5: sequential reads across 7FFF -> 0
    loadAddr = 1; loadValue = 15'h7FFD; step("R2");
    step("R5");
    for (int i = 0; i < 5; i++) begin
      rdNext = 1; step("R5"); step("R5");
    end
    check(curAddr == 15'h0002, "R5", "read wrap", curAddr, 15'h0002);

    // R6: mask clearing alone and with a byte
    wrStart = 1; step("R6");
    check(validMask == 0, "R6", "mask cleared", validMask, 0);
    wrByte = 1; wrData = 8'h11; step("R6");
    wrStart = 1; wrByte = 1; wrData = 8'h22; step("R6");
    check(validMask == 64'h8, "R6", "mask one bit", validMask, 64'h8);

    // R2 / R8: same-cycle priorities
    loadAddr = 1; loadValue = 15'h0400; wrByte = 1; wrData = 8'h99; step("R2");
    step("R8");
    wrByte = 1; rdNext = 1; wrData = 8'h77; step("R8");
    check(curAddr == 15'h0401, "R8", "write wins", curAddr, 15'h0401);

    // Mixed traffic
    lfsr = 16'hACE1; prevChg = 1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      k = int'(lfsr[2:0]);
      commitIdx = lfsr[10:5];
      wrData = lfsr[15:8];
      case (k)
        0: begin loadAddr = 1; loadValue = lfsr[14:0]; end
        1, 2, 3: wrByte = 1;
        4, 5: rdNext = !prevChg;
        6: wrStart = 1;
        default: ;
      endcase
      prevChg = loadAddr | wrByte | rdNext;
      step("R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule